// File: doc/BRIEF.md
# External Memory Interface Controller

This block lets a DSP reach an external byte-wide SRAM, EPROM or flash through a 22-bit address. The DSP sees a small set of registers. Software never handles the external bus timing. It writes a word to start a store, or it writes an offset or reads the read-data register to start a fetch. The controller then runs the bus cycles. A word of 8, 16 or 24 bits is split into byte cycles. Each byte goes to a consecutive address, starting at a base address plus one of two offsets, and the offset in use advances by the word length after each word.

Each byte cycle has three parts. First comes one address-latch cycle. In it, the low eight address bits appear on the shared address/data lines and the latch strobe is high. Next comes a read or write strobe whose width is one of four settings. Last comes a quiet cycle. Software learns that a transfer has finished either by polling a status bit or through an interrupt output.

Top module: `ext_mem_ctrl`

## Requirements
- R1: After reset, both strobes are high, the latch strobe is low, the shared lines are not driven, busy, error and done read 0, and irq is 0.
- R2: Writing register 4 (write data) starts an external write. Control bits [1:0] set the length: code 0 gives 1 byte, code 1 gives 2 bytes, and codes 2 and 3 give 3 bytes. Bytes go least significant first, to consecutive addresses beginning at base (register 1) plus the offset register that control bit 5 selects (0 selects register 2, 1 selects register 3).
- R3: Every byte cycle has exactly one cycle with ale high. In that cycle mem_ad_out carries address bits [7:0] and mem_addr_hi carries bits [21:8]. Then one strobe stays low for (control bits [3:2]) + 1 cycles. Then one cycle follows with both strobes high and ale low. During a write strobe the lines carry the data byte. During a read strobe mem_ad_oe is 0.
- R4: When control bit 4 is 0, writing register 2 or 3 loads that offset and starts a read that uses it.
- R5: When control bit 4 is 1, a read strobe on register 5 returns the data already held there and starts a read at base plus the selected offset. Offset writes in this mode only load the register and start no access.
- R6: A read assembles the bytes least significant first and zero-extends the result. The result is visible in register 5 once busy has fallen. Each byte is sampled from mem_ad_in on the last cycle of its strobe.
- R7: The byte address wraps modulo 2^22. After each word, the offset register used advances by the number of bytes, also modulo 2^22.
- R8: Reading register 0 returns the configuration in bits [6:0], busy in bit 7, error in bit 8 and done in bit 9. Busy is 1 from the clock edge that accepts a start until the edge that ends the quiet cycle of the last byte, which is n*(strobe width + 2) cycles later.
- R9: While busy, a write to register 2, 3 or 4, or a read strobe on register 5 in mode 1, is ignored and sets error. A control write while busy leaves the configuration unchanged. Writing 1 to control bit 8 clears error.
- R10: irq equals done AND control bit 6.
- R11: Done is set when a transfer ends, cleared when a new one starts, and cleared by writing 1 to control bit 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (has an effect only on register 5) |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Register read data for reg_addr, combinational |
| irq | output | 1 | Transfer-complete interrupt, level |
| mem_addr_hi | output | 14 | Address bits [21:8] |
| mem_ad_out | output | 8 | Shared lines: address bits [7:0] or write data |
| mem_ad_oe | output | 1 | Drive enable for the shared lines |
| mem_ad_in | input | 8 | Read data from the shared lines |
| mem_ale | output | 1 | Address latch strobe, active high |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |

## Verification
The bench builds the block with its default parameters: a 22-bit address, a 24-bit word and byte-wide lanes. With these values the bench reaches all three word lengths and all four strobe widths. It also reaches a byte run that carries into mem_addr_hi and an offset that wraps past 2^22 - 1. A simple external memory model returns an address-derived byte, so every assembled read word can be predicted.

// File: rtl/emi_pkg.sv
// Package: shared types and register indices for the external memory
// interface controller. Assumes a 3-bit register index.
package emi_pkg;
    localparam int RA_W = 3;

    localparam logic [RA_W-1:0] RA_CTRL  = 3'd0;
    localparam logic [RA_W-1:0] RA_BASE  = 3'd1;
    localparam logic [RA_W-1:0] RA_OFF0  = 3'd2;
    localparam logic [RA_W-1:0] RA_OFF1  = 3'd3;
    localparam logic [RA_W-1:0] RA_WDATA = 3'd4;
    localparam logic [RA_W-1:0] RA_RDATA = 3'd5;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ALE,
        SQ_STB,
        SQ_GAP
    } sq_state_t;
endpackage

// File: rtl/emi_byte_seq.sv
// Module: byte cycle sequencer. For each byte it runs one latch cycle,
// then a strobe of (tim+1) cycles, then one quiet cycle. Bytes go to
// consecutive addresses, least significant byte first.
// Assumes: start_i arrives only while busy_o is low, and nbytes_i >= 1.
module emi_byte_seq
    import emi_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 24,
    parameter int BYTE_W = 8,
    parameter int TIM_W  = 2,
    localparam int NB_W  = $clog2(DATA_W / BYTE_W + 1),
    localparam int HI_W  = ADDR_W - BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              start_write_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [NB_W-1:0]   nbytes_i,
    input  logic [TIM_W-1:0]  tim_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [BYTE_W-1:0] ad_in_i,
    output logic              busy_o,
    output logic              fin_o,
    output logic              fin_rd_o,
    output logic [DATA_W-1:0] rword_o,
    output logic [HI_W-1:0]   addr_hi_o,
    output logic [BYTE_W-1:0] ad_out_o,
    output logic              ad_oe_o,
    output logic              ale_o,
    output logic              rd_n_o,
    output logic              wr_n_o
);
    sq_state_t         state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wsh_q;
    logic [DATA_W-1:0] asm_q;
    logic [NB_W-1:0]   idx_q;
    logic [NB_W-1:0]   last_q;
    logic [TIM_W-1:0]  cnt_q;
    logic [TIM_W-1:0]  tim_q;
    logic              wr_q;

    // Step through the latch, strobe and quiet phases for each byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            addr_q  <= '0;
            wsh_q   <= '0;
            asm_q   <= '0;
            idx_q   <= '0;
            last_q  <= '0;
            cnt_q   <= '0;
            tim_q   <= '0;
            wr_q    <= 1'b0;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    if (start_i) begin
                        state_q <= SQ_ALE;
                        addr_q  <= start_addr_i;
                        wsh_q   <= wdata_i;
                        asm_q   <= '0;
                        idx_q   <= '0;
                        last_q  <= nbytes_i - NB_W'(1);
                        tim_q   <= tim_i;
                        wr_q    <= start_write_i;
                    end
                end
                SQ_ALE: begin
                    state_q <= SQ_STB;
                    cnt_q   <= '0;
                end
                SQ_STB: begin
                    if (cnt_q == tim_q) begin
                        if (!wr_q) asm_q[idx_q*BYTE_W +: BYTE_W] <= ad_in_i;
                        state_q <= SQ_GAP;
                    end else begin
                        cnt_q <= cnt_q + TIM_W'(1);
                    end
                end
                default: begin
                    if (idx_q == last_q) begin
                        state_q <= SQ_IDLE;
                    end else begin
                        idx_q   <= idx_q + NB_W'(1);
                        addr_q  <= addr_q + ADDR_W'(1);
                        wsh_q   <= wsh_q >> BYTE_W;
                        state_q <= SQ_ALE;
                    end
                end
            endcase
        end
    end

    // Decode the external pins and the completion flags from the phase.
    assign busy_o    = (state_q != SQ_IDLE);
    assign fin_o     = (state_q == SQ_GAP) && (idx_q == last_q);
    assign fin_rd_o  = fin_o && !wr_q;
    assign rword_o   = asm_q;
    assign addr_hi_o = addr_q[ADDR_W-1:BYTE_W];
    assign ale_o     = (state_q == SQ_ALE);
    assign ad_out_o  = ale_o ? addr_q[BYTE_W-1:0] : wsh_q[BYTE_W-1:0];
    assign ad_oe_o   = ale_o || ((state_q == SQ_STB) && wr_q);
    assign rd_n_o    = !((state_q == SQ_STB) && !wr_q);
    assign wr_n_o    = !((state_q == SQ_STB) && wr_q);

    a_r3_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
        ale_o |=> !ale_o);
    a_r3_quiet_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n_o || !wr_n_o) ##1 (rd_n_o && wr_n_o) |-> !ale_o);
    a_r3_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> !ad_oe_o);
    a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n_o && !wr_n_o));
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (rd_n_o && wr_n_o && !ale_o));
endmodule

// File: rtl/emi_regs.sv
// Module: register file and launch logic. It holds the configuration,
// the base, the two offsets, the read data and the error and done
// flags. It decides when an access starts and which address it uses.
// Assumes: reg_wr and reg_rd are never high in the same cycle, and
// DATA_W >= ADDR_W and DATA_W >= 10.
module emi_regs
    import emi_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 24,
    parameter int BYTE_W = 8,
    parameter int TIM_W  = 2,
    localparam int MAX_B = DATA_W / BYTE_W,
    localparam int NB_W  = $clog2(MAX_B + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    input  logic              busy_i,
    input  logic              fin_i,
    input  logic              fin_rd_i,
    input  logic [DATA_W-1:0] rword_i,
    output logic              start_o,
    output logic              start_write_o,
    output logic [ADDR_W-1:0] start_addr_o,
    output logic [NB_W-1:0]   nbytes_o,
    output logic [TIM_W-1:0]  tim_o,
    output logic [DATA_W-1:0] wdata_o
);
    logic [1:0]        len_q;
    logic [TIM_W-1:0]  tim_q;
    logic              rmode_q, osel_q, irqen_q, err_q, done_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] off_q [2];
    logic [DATA_W-1:0] rdata_q;

    logic wr_ctrl, wr_off, want_wr, want_rd_off, want_pop, blocked, sel;
    logic [ADDR_W-1:0] off_val;
    logic [NB_W:0]     len_plus;

    // Decode register accesses into start and error requests.
    always_comb begin
        wr_ctrl     = reg_wr && (reg_addr == RA_CTRL);
        wr_off      = reg_wr && ((reg_addr == RA_OFF0) || (reg_addr == RA_OFF1));
        want_wr     = reg_wr && (reg_addr == RA_WDATA);
        want_rd_off = wr_off && !rmode_q;
        want_pop    = reg_rd && (reg_addr == RA_RDATA) && rmode_q;
        blocked     = busy_i && (want_wr || wr_off || want_pop);
        start_o     = (want_wr || want_rd_off || want_pop) && !busy_i;
        sel         = want_rd_off ? reg_addr[0] : osel_q;
        off_val     = want_rd_off ? reg_wdata[ADDR_W-1:0] : off_q[sel];
        len_plus    = (NB_W+1)'(len_q) + (NB_W+1)'(1);
        nbytes_o    = (len_plus > (NB_W+1)'(MAX_B)) ? NB_W'(MAX_B) : len_plus[NB_W-1:0];
    end

    assign start_write_o = want_wr;
    assign start_addr_o  = base_q + off_val;
    assign tim_o         = tim_q;
    assign wdata_o       = reg_wdata;
    assign irq           = done_q && irqen_q;

    // Update the configuration, the addresses, the flags and the read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q   <= '0;
            tim_q   <= '0;
            rmode_q <= 1'b0;
            osel_q  <= 1'b0;
            irqen_q <= 1'b0;
            err_q   <= 1'b0;
            done_q  <= 1'b0;
            base_q  <= '0;
            off_q   <= '{default: '0};
            rdata_q <= '0;
        end else begin
            if (wr_ctrl && !busy_i) begin
                len_q   <= reg_wdata[1:0];
                tim_q   <= reg_wdata[2 +: TIM_W];
                rmode_q <= reg_wdata[4];
                osel_q  <= reg_wdata[5];
                irqen_q <= reg_wdata[6];
            end
            if (reg_wr && (reg_addr == RA_BASE)) base_q <= reg_wdata[ADDR_W-1:0];
            if (wr_off && !busy_i) off_q[reg_addr[0]] <= reg_wdata[ADDR_W-1:0];
            if (start_o) off_q[sel] <= off_val + ADDR_W'(nbytes_o);
            if (blocked) err_q <= 1'b1;
            else if (wr_ctrl && reg_wdata[8]) err_q <= 1'b0;
            if (start_o) done_q <= 1'b0;
            else if (fin_i) done_q <= 1'b1;
            else if (wr_ctrl && reg_wdata[9]) done_q <= 1'b0;
            if (fin_rd_i) rdata_q <= rword_i;
        end
    end

    // Return the selected register on the read port.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL: begin
                reg_rdata[1:0]       = len_q;
                reg_rdata[2 +: TIM_W] = tim_q;
                reg_rdata[4]         = rmode_q;
                reg_rdata[5]         = osel_q;
                reg_rdata[6]         = irqen_q;
                reg_rdata[7]         = busy_i;
                reg_rdata[8]         = err_q;
                reg_rdata[9]         = done_q;
            end
            RA_BASE:  reg_rdata[ADDR_W-1:0] = base_q;
            RA_OFF0:  reg_rdata[ADDR_W-1:0] = off_q[0];
            RA_OFF1:  reg_rdata[ADDR_W-1:0] = off_q[1];
            RA_RDATA: reg_rdata = rdata_q;
            default:  reg_rdata = '0;
        endcase
    end

    a_r9_err_on_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && reg_wr && (reg_addr == RA_WDATA)) |=> err_q);
    a_r11_start_makes_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> (busy_i && !done_q));
    a_r11_done_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
        fin_i |=> done_q);
endmodule

// File: rtl/ext_mem_ctrl.sv
// Module: top of the external memory interface controller. It connects
// the register file to the byte sequencer and exposes the external
// multiplexed bus. Assumes: synchronous active-low reset, and the
// external device answers within the programmed strobe width.
module ext_mem_ctrl
    import emi_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 24,
    parameter int BYTE_W = 8,
    parameter int TIM_W  = 2,
    localparam int NB_W  = $clog2(DATA_W / BYTE_W + 1),
    localparam int HI_W  = ADDR_W - BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic [HI_W-1:0]   mem_addr_hi,
    output logic [BYTE_W-1:0] mem_ad_out,
    output logic              mem_ad_oe,
    input  logic [BYTE_W-1:0] mem_ad_in,
    output logic              mem_ale,
    output logic              mem_rd_n,
    output logic              mem_wr_n
);
    logic              busy, fin, fin_rd, start, start_write;
    logic [DATA_W-1:0] rword, wdata;
    logic [ADDR_W-1:0] start_addr;
    logic [NB_W-1:0]   nbytes;
    logic [TIM_W-1:0]  tim;

    emi_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W), .TIM_W(TIM_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .busy_i(busy), .fin_i(fin), .fin_rd_i(fin_rd),
        .rword_i(rword), .start_o(start), .start_write_o(start_write),
        .start_addr_o(start_addr), .nbytes_o(nbytes), .tim_o(tim),
        .wdata_o(wdata)
    );

    emi_byte_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W), .TIM_W(TIM_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .start_write_i(start_write),
        .start_addr_i(start_addr), .nbytes_i(nbytes), .tim_i(tim),
        .wdata_i(wdata), .ad_in_i(mem_ad_in), .busy_o(busy), .fin_o(fin),
        .fin_rd_o(fin_rd), .rword_o(rword), .addr_hi_o(mem_addr_hi),
        .ad_out_o(mem_ad_out), .ad_oe_o(mem_ad_oe), .ale_o(mem_ale),
        .rd_n_o(mem_rd_n), .wr_n_o(mem_wr_n)
    );
endmodule

// File: tb/tb_ext_mem_ctrl.sv
module tb_ext_mem_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [23:0] reg_wdata = '0;
    logic [23:0] reg_rdata;
    logic        irq;
    logic [13:0] mem_addr_hi;
    logic [7:0]  mem_ad_out, mem_ad_in;
    logic        mem_ad_oe, mem_ale, mem_rd_n, mem_wr_n;

    int n_chk = 0, n_fail = 0;

    ext_mem_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .mem_addr_hi(mem_addr_hi), .mem_ad_out(mem_ad_out),
        .mem_ad_oe(mem_ad_oe), .mem_ad_in(mem_ad_in), .mem_ale(mem_ale),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n)
    );

    always #2 clk = ~clk;

    function automatic logic [7:0] fmem(input logic [21:0] a);
        return a[7:0] ^ a[15:8] ^ {a[21:16], 2'b00} ^ 8'h5A;
    endfunction

    // External memory model and bus monitor
    logic [21:0] lat_addr = '0;
    logic        prev_wr_n = 1'b1, prev_stb = 1'b0, prev_ale = 1'b0;
    int          wcount = 0, pcount = 0, stb_run = 0, gap_viol = 0, ale_viol = 0, ale_cnt = 0;
    logic [21:0] wlog_a [32];
    logic [7:0]  wlog_d [32];
    int          plog [64];

    assign mem_ad_in = fmem(lat_addr);

    always @(posedge clk) begin
        if (mem_ale) begin
            lat_addr <= {mem_addr_hi, mem_ad_out};
            ale_cnt  <= ale_cnt + 1;
        end
        if (!mem_wr_n && prev_wr_n && wcount < 32) begin
            wlog_a[wcount] <= lat_addr;
            wlog_d[wcount] <= mem_ad_out;
            wcount <= wcount + 1;
        end
        if (!mem_rd_n || !mem_wr_n) stb_run <= stb_run + 1;
        else if (stb_run != 0) begin
            if (pcount < 64) plog[pcount] <= stb_run;
            pcount  <= pcount + 1;
            stb_run <= 0;
        end
        if (mem_ale && prev_stb) gap_viol <= gap_viol + 1;
        if (mem_ale && prev_ale) ale_viol <= ale_viol + 1;
        prev_wr_n <= mem_wr_n;
        prev_stb  <= !mem_rd_n || !mem_wr_n;
        prev_ale  <= mem_ale;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [23:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [23:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pop(output logic [23:0] d);
        @(negedge clk);
        reg_addr = 3'd5; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // Counts busy cycles from the current point until idle
    task automatic busy_cycles(output int n);
        logic [23:0] v;
        n = 0;
        reg_addr = 3'd0;
        #1 v = reg_rdata;
        while (v[7] && n < 1000) begin
            n++;
            @(negedge clk);
            #1 v = reg_rdata;
        end
    endtask

    task automatic chk_widths(input string req, input int from, input int cnt, input int w);
        for (int i = from; i < from + cnt; i++) chk(req, plog[i], w);
    endtask

    task automatic t_reset();
        logic [23:0] v;
        peek(3'd0, v);
        chk("R1 status", {22'd0, v[9:7]}, 0);
        chk("R1 strobes", {mem_rd_n, mem_wr_n, mem_ale, mem_ad_oe}, 4'b1100);
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_write24();
        int w0, p0, n;
        logic [23:0] v;
        reg_write(3'd0, 24'h56);
        reg_write(3'd1, 24'h012300);
        reg_write(3'd2, 24'h0000FE);
        w0 = wcount; p0 = pcount;
        reg_write(3'd4, 24'hA1B2C3);
        busy_cycles(n);
        chk("R8 busy span 24b w2", n, 12);
        @(negedge clk);
        chk("R2 byte count", wcount - w0, 3);
        chk("R2 addr0", wlog_a[w0], 22'h0123FE);
        chk("R2 data0", wlog_d[w0], 8'hC3);
        chk("R3 addr carry", wlog_a[w0+2], 22'h012400);
        chk("R2 data2", {wlog_d[w0+1], wlog_d[w0+2]}, 16'hB2A1);
        chk_widths("R3 strobe width 2", p0, 3, 2);
        peek(3'd2, v);
        chk("R7 offset advance", v, 24'h000101);
        peek(3'd0, v);
        chk("R11 done set", v[9], 1);
        chk("R10 irq on", irq, 1);
        reg_write(3'd0, 24'h256);
        #1 chk("R11 done w1c irq off", irq, 0);
    endtask

    task automatic t_write16_wrap();
        int w0, p0;
        logic [23:0] v;
        reg_write(3'd0, 24'h03D);
        reg_write(3'd1, 24'h000010);
        reg_write(3'd3, 24'h3FFFFF);
        w0 = wcount; p0 = pcount;
        reg_write(3'd4, 24'h00BEEF);
        repeat (14) @(negedge clk);
        chk("R7 wrap addr", wlog_a[w0], 22'h00000F);
        chk("R2 16b data", {wlog_d[w0], wlog_d[w0+1]}, 16'hEFBE);
        chk("R2 16b count", wcount - w0, 2);
        chk_widths("R3 strobe width 4", p0, 2, 4);
        peek(3'd3, v);
        chk("R7 offset wrap", v, 24'h000001);
        peek(3'd0, v);
        chk("R10 irq masked", {v[9], irq}, 2'b10);
    endtask

    task automatic t_read_mode0();
        int w0, p0, n;
        logic [23:0] v;
        logic [21:0] a;
        reg_write(3'd0, 24'h202);
        reg_write(3'd1, 24'h012300);
        w0 = wcount; p0 = pcount;
        reg_write(3'd2, 24'h000040);
        busy_cycles(n);
        chk("R4 busy span 24b w1", n, 9);
        a = 22'h012340;
        peek(3'd5, v);
        chk("R6 read word", v, {fmem(a + 22'd2), fmem(a + 22'd1), fmem(a)});
        chk_widths("R3 strobe width 1", p0, 3, 1);
        chk("R4 no write", wcount - w0, 0);
        peek(3'd2, v);
        chk("R7 offset after read", v, 24'h000043);
    endtask

    task automatic t_read_mode1();
        int a0, n;
        logic [23:0] v, prev;
        peek(3'd5, prev);
        reg_write(3'd0, 24'h238);
        a0 = ale_cnt;
        reg_write(3'd3, 24'h0000AA);
        peek(3'd0, v);
        repeat (3) @(negedge clk);
        chk("R5 offset write no start", {v[7], 8'(ale_cnt - a0)}, 0);
        pop(v);
        chk("R5 pop returns held", v, prev);
        busy_cycles(n);
        chk("R8 busy span 8b w3", n, 5);
        peek(3'd5, v);
        chk("R6 zero-extended byte", v, {16'd0, fmem(22'h0123AA)});
        chk("R3 strobe width 3", plog[pcount-1], 3);
        peek(3'd3, v);
        chk("R7 offset 8b", v, 24'h0000AB);
    endtask

    task automatic t_busy_error();
        int w0;
        logic [23:0] v;
        reg_write(3'd0, 24'h21E);
        w0 = wcount;
        reg_write(3'd4, 24'h112233);
        reg_write(3'd4, 24'h445566);
        reg_write(3'd2, 24'h000000);
        reg_write(3'd0, 24'h000000);
        peek(3'd0, v);
        chk("R9 error while busy", {v[8:7], 1'b0, v[6:0]}, {2'b11, 1'b0, 7'h1E});
        repeat (20) @(negedge clk);
        chk("R9 only one word", wcount - w0, 3);
        chk("R9 data kept", {wlog_d[w0], wlog_d[w0+1], wlog_d[w0+2]}, 24'h332211);
        peek(3'd2, v);
        chk("R9 offset write ignored", v, 24'h000046);
        reg_write(3'd0, 24'h11E);
        peek(3'd0, v);
        chk("R9 error cleared", v[8], 0);
        chk("R3 quiet and single latch", gap_viol + ale_viol, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write24();
        t_write16_wrap();
        t_read_mode0();
        t_read_mode1();
        t_busy_error();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule